// File: doc/BRIEF.md
# Multi-Block Sync Strobe Controller

This block turns a synchronization trigger into one-cycle strobes for six downstream transmit-path blocks: a clock divider, a FIFO pointer pair, an offset-correction bank, a gain/phase-correction bank, an NCO phase accumulator and a power meter. The trigger is either a rising edge on an asynchronous sync pin or a 0-to-1 change of a software control bit. The pin passes through a two-flop synchronizer before edge detection.

There are two sides, TX and RX. Each side has its own source select, its own global-disable bit and its own sequencer. In global mode, which is the reset default, one trigger fires every block in a fixed order over three consecutive cycles. The divider fires first, then the FIFO, then the other four blocks together. In per-block mode each block has an enable, and it fires on the pin edge or on its own software bit. The TX strobes also drive a small model of the affected state: FIFO write and read pointers, and shadowed offset and gain/phase values that are copied to their active copies when the matching strobe fires. An idle pin held low leaves every block running.

Top module: `sync_strobe_ctrl`

## Requirements
- R1: While reset is held, all strobes are 0, the write pointer is 0, the read pointer is 4, and every active offset, gain and phase value is 0.
- R2: With software source off (srcSw=0) in global mode, a rising edge on syncPin first sampled at clock edge k gives a divider strobe after edge k+2. A falling edge or a steady level gives no strobe.
- R3: With srcSw=1, a 0-to-1 change of the side's swTrig, sampled at edge k, gives a divider strobe after that same edge k. Holding the bit high does not repeat it, and pin edges are ignored on that side.
- R4: Strobe vectors use bit 0 for the divider, bit 1 for the FIFO, bit 2 for offset, bit 3 for gain/phase, bit 4 for the NCO and bit 5 for the power meter. A global sequence is 6'b000001, then 6'b000010, then 6'b111100 on consecutive cycles, then all zero.
- R5: A trigger that arrives while a global sequence is still running is dropped and starts no new sequence.
- R6: With globalDis=1, a trigger fires only the blocks whose blkEn bit is set, all in the same cycle. The source is the pin edge (same timing as R2) or the block's own blkSwTrig rising bit (same timing as R3). The side's swTrig has no effect in this mode.
- R7: The cycle after the TX FIFO strobe, the write pointer is 0 and the read pointer is 4. After that both pointers advance by one each cycle and wrap modulo 8.
- R8: With ofsNeedSync=0, the active offsets follow the configured offsets one cycle later. With ofsNeedSync=1, they hold their value and load the configured values only on the cycle after the TX offset strobe.
- R9: The active gain and phase values load the configured values on the cycle after the TX gain/phase strobe, and hold otherwise.
- R10: The TX and RX sides are independent. A side with software source ignores a pin edge that triggers the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncPin | input | 1 | Asynchronous sync pin shared by both sides |
| txSrcSw | input | 1 | TX trigger source: 0 pin, 1 software bit |
| txGlobalDis | input | 1 | TX: 1 selects per-block mode |
| txSwTrig | input | 1 | TX global software trigger bit |
| txBlkEn | input | 6 | TX per-block enables |
| txBlkSwTrig | input | 6 | TX per-block software trigger bits |
| rxSrcSw | input | 1 | RX trigger source select |
| rxGlobalDis | input | 1 | RX: 1 selects per-block mode |
| rxSwTrig | input | 1 | RX global software trigger bit |
| rxBlkEn | input | 6 | RX per-block enables |
| rxBlkSwTrig | input | 6 | RX per-block software trigger bits |
| ofsNeedSync | input | 1 | 1: offsets load only on the offset strobe |
| ofsCfgA | input | 13 | Configured offset, path A |
| ofsCfgB | input | 13 | Configured offset, path B |
| gainCfg | input | 12 | Configured gain correction |
| phaseCfg | input | 12 | Configured phase correction |
| txStrobe | output | 6 | TX strobes (bit map in R4) |
| rxStrobe | output | 6 | RX strobes (bit map in R4) |
| wrPtr | output | 3 | FIFO write pointer model |
| rdPtr | output | 3 | FIFO read pointer model |
| ofsActA | output | 13 | Active offset, path A |
| ofsActB | output | 13 | Active offset, path B |
| gainAct | output | 12 | Active gain correction |
| phaseAct | output | 12 | Active phase correction |

## Verification
The assertions check the following on every cycle: the fixed order of the three sequence steps, that a trigger cannot restart a sequence mid-flight, that strobes last one cycle, and how the pointers and active registers respond to their strobes. Some properties can only be shown by the bench scenarios. These are the exact latency from the pin through the synchronizer, that a held level or falling edge triggers nothing, that per-block enables mask the right bits under each source, and that TX and RX stay separate when one is on the pin and the other on software.

// File: rtl/sync_ctrl_pkg.sv
package sync_ctrl_pkg;
  localparam int NUM_BLK = 6;
  localparam int BLK_DIV = 0;
  localparam int BLK_FIFO = 1;

  typedef struct packed {
    logic pwr;
    logic nco;
    logic qmc;
    logic ofs;
    logic fifo;
    logic div;
  } sync_strobe_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_FIFO = 2'd1,
    SEQ_REST = 2'd2
  } seq_state_e;

  localparam logic [NUM_BLK-1:0] MASK_DIV  = 6'b000001;
  localparam logic [NUM_BLK-1:0] MASK_FIFO = 6'b000010;
  localparam logic [NUM_BLK-1:0] MASK_REST = 6'b111100;
endpackage

// File: rtl/sync_pin_edge.sv
module sync_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinAsync,
  output logic edgePulse
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic pinPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      pinPrev   <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], pinAsync};
      pinPrev   <= syncChain[SYNC_STAGES-1];
    end
  end

  assign edgePulse = syncChain[SYNC_STAGES-1] & ~pinPrev;

  // R2: a detected edge is a single-cycle pulse
  p_edge_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !edgePulse);
endmodule

// File: rtl/sync_ctrl_seq.sv
module sync_ctrl_seq
  import sync_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinEdge,
  input  logic               srcSw,
  input  logic               globalDis,
  input  logic               swTrig,
  input  logic [NUM_BLK-1:0] blkEn,
  input  logic [NUM_BLK-1:0] blkSwTrig,
  output sync_strobe_t       stb
);
  seq_state_e         seqState, seqNext;
  logic               swPrev;
  logic [NUM_BLK-1:0] blkPrev;
  logic [NUM_BLK-1:0] blkTrig;
  logic [NUM_BLK-1:0] stbVec, stbNext;
  logic               globalTrig;

  assign globalTrig = srcSw ? (swTrig & ~swPrev) : pinEdge;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blkTrig[b] = blkEn[b] & (srcSw ? (blkSwTrig[b] & ~blkPrev[b]) : pinEdge);
  end

  always_comb begin
    stbNext = '0;
    seqNext = seqState;
    unique case (seqState)
      SEQ_IDLE: begin
        if (globalDis) begin
          stbNext = blkTrig;
        end else if (globalTrig) begin
          stbNext = MASK_DIV;
          seqNext = SEQ_FIFO;
        end
      end
      SEQ_FIFO: begin
        stbNext = MASK_FIFO;
        seqNext = SEQ_REST;
      end
      SEQ_REST: begin
        stbNext = MASK_REST;
        seqNext = SEQ_IDLE;
      end
      default: seqNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      stbVec   <= '0;
      swPrev   <= 1'b0;
      blkPrev  <= '0;
    end else begin
      seqState <= seqNext;
      stbVec   <= stbNext;
      swPrev   <= swTrig;
      blkPrev  <= blkSwTrig;
    end
  end

  assign stb = sync_strobe_t'(stbVec);

  // R4: divider strobe accompanies entry to the FIFO step
  p_div_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_FIFO) |-> (stbVec == MASK_DIV));
  // R4: FIFO strobe alone in the second step
  p_fifo_second_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_REST) |-> (stbVec == MASK_FIFO));
  // R4: remaining blocks together, then back to idle
  p_rest_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_REST) |=> (stbVec == MASK_REST && seqState == SEQ_IDLE));
  // R5: no new divider strobe while a sequence runs
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (seqState != SEQ_IDLE) |=> !stb.div);
  // R3: divider strobe never lasts two cycles
  p_div_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.div |=> !stb.div);
endmodule

// File: rtl/sync_ctrl_dp.sv
module sync_ctrl_dp
  import sync_ctrl_pkg::*;
#(
  parameter int OFS_W      = 13,
  parameter int GAIN_W     = 12,
  parameter int PHASE_W    = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int RD_START   = 4,
  localparam int PTR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  sync_strobe_t       stb,
  input  logic               ofsNeedSync,
  input  logic [OFS_W-1:0]   ofsCfgA,
  input  logic [OFS_W-1:0]   ofsCfgB,
  input  logic [GAIN_W-1:0]  gainCfg,
  input  logic [PHASE_W-1:0] phaseCfg,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [OFS_W-1:0]   ofsActA,
  output logic [OFS_W-1:0]   ofsActB,
  output logic [GAIN_W-1:0]  gainAct,
  output logic [PHASE_W-1:0] phaseAct
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [PTR_W-1:0] RD_RST   = PTR_W'(RD_START);

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= RD_RST;
    end else if (stb.fifo) begin
      wrPtr <= '0;
      rdPtr <= RD_RST;
    end else begin
      wrPtr <= ptrInc(wrPtr);
      rdPtr <= ptrInc(rdPtr);
    end
  end

  logic [OFS_W-1:0] ofsCfg [2];
  logic [OFS_W-1:0] ofsAct [2];
  logic             ofsLoad;
  assign ofsCfg[0] = ofsCfgA;
  assign ofsCfg[1] = ofsCfgB;
  assign ofsLoad   = !ofsNeedSync || stb.ofs;

  for (genvar c = 0; c < 2; c++) begin : g_ofs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ofsAct[c] <= '0;
      else if (ofsLoad) ofsAct[c] <= ofsCfg[c];
    end
  end
  assign ofsActA = ofsAct[0];
  assign ofsActB = ofsAct[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainAct  <= '0;
      phaseAct <= '0;
    end else if (stb.qmc) begin
      gainAct  <= gainCfg;
      phaseAct <= phaseCfg;
    end
  end

  // R7: pointers land on their reset offsets after a FIFO strobe
  p_fifo_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.fifo |=> (wrPtr == '0 && rdPtr == RD_RST));
  // R7: read leads write by a constant distance between syncs
  p_ptr_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr - wrPtr) == RD_RST);
  // R8: offsets hold when sync is needed and no strobe arrives
  p_ofs_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ofsNeedSync && !stb.ofs) |=> $stable(ofsActA) && $stable(ofsActB));
  // R9: gain/phase take the configured values on their strobe
  p_qmc_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.qmc |=> (gainAct == $past(gainCfg) && phaseAct == $past(phaseCfg)));
endmodule

// File: rtl/sync_strobe_ctrl.sv
module sync_strobe_ctrl
  import sync_ctrl_pkg::*;
#(
  parameter int OFS_W      = 13,
  parameter int GAIN_W     = 12,
  parameter int PHASE_W    = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int RD_START   = 4,
  localparam int PTR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncPin,
  input  logic               txSrcSw,
  input  logic               txGlobalDis,
  input  logic               txSwTrig,
  input  logic [NUM_BLK-1:0] txBlkEn,
  input  logic [NUM_BLK-1:0] txBlkSwTrig,
  input  logic               rxSrcSw,
  input  logic               rxGlobalDis,
  input  logic               rxSwTrig,
  input  logic [NUM_BLK-1:0] rxBlkEn,
  input  logic [NUM_BLK-1:0] rxBlkSwTrig,
  input  logic               ofsNeedSync,
  input  logic [OFS_W-1:0]   ofsCfgA,
  input  logic [OFS_W-1:0]   ofsCfgB,
  input  logic [GAIN_W-1:0]  gainCfg,
  input  logic [PHASE_W-1:0] phaseCfg,
  output logic [NUM_BLK-1:0] txStrobe,
  output logic [NUM_BLK-1:0] rxStrobe,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [OFS_W-1:0]   ofsActA,
  output logic [OFS_W-1:0]   ofsActB,
  output logic [GAIN_W-1:0]  gainAct,
  output logic [PHASE_W-1:0] phaseAct
);
  logic         pinEdge;
  sync_strobe_t txStb, rxStb;

  sync_pin_edge #(.SYNC_STAGES(2)) i_pin (
    .clk(clk), .rstN(rstN), .pinAsync(syncPin), .edgePulse(pinEdge)
  );

  sync_ctrl_seq i_txSeq (
    .clk(clk), .rstN(rstN), .pinEdge(pinEdge), .srcSw(txSrcSw),
    .globalDis(txGlobalDis), .swTrig(txSwTrig), .blkEn(txBlkEn),
    .blkSwTrig(txBlkSwTrig), .stb(txStb)
  );

  sync_ctrl_seq i_rxSeq (
    .clk(clk), .rstN(rstN), .pinEdge(pinEdge), .srcSw(rxSrcSw),
    .globalDis(rxGlobalDis), .swTrig(rxSwTrig), .blkEn(rxBlkEn),
    .blkSwTrig(rxBlkSwTrig), .stb(rxStb)
  );

  sync_ctrl_dp #(
    .OFS_W(OFS_W), .GAIN_W(GAIN_W), .PHASE_W(PHASE_W),
    .FIFO_DEPTH(FIFO_DEPTH), .RD_START(RD_START)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(txStb), .ofsNeedSync(ofsNeedSync),
    .ofsCfgA(ofsCfgA), .ofsCfgB(ofsCfgB), .gainCfg(gainCfg), .phaseCfg(phaseCfg),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .ofsActA(ofsActA), .ofsActB(ofsActB),
    .gainAct(gainAct), .phaseAct(phaseAct)
  );

  assign txStrobe = txStb;
  assign rxStrobe = rxStb;
endmodule

// File: tb/test_sync_strobe_ctrl.sv
module test_sync_strobe_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncPin = 0, txSrcSw = 0, txGlobalDis = 0, txSwTrig = 0;
  logic rxSrcSw = 0, rxGlobalDis = 0, rxSwTrig = 0, ofsNeedSync = 0;
  logic [5:0] txBlkEn = 0, txBlkSwTrig = 0, rxBlkEn = 0, rxBlkSwTrig = 0;
  logic [12:0] ofsCfgA = 0, ofsCfgB = 0;
  logic [11:0] gainCfg = 0, phaseCfg = 0;
  logic [5:0] txStrobe, rxStrobe;
  logic [2:0] wrPtr, rdPtr;
  logic [12:0] ofsActA, ofsActB;
  logic [11:0] gainAct, phaseAct;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  sync_strobe_ctrl i_sync_strobe_ctrl (
    .clk(clk), .rstN(rstN), .syncPin(syncPin),
    .txSrcSw(txSrcSw), .txGlobalDis(txGlobalDis), .txSwTrig(txSwTrig),
    .txBlkEn(txBlkEn), .txBlkSwTrig(txBlkSwTrig),
    .rxSrcSw(rxSrcSw), .rxGlobalDis(rxGlobalDis), .rxSwTrig(rxSwTrig),
    .rxBlkEn(rxBlkEn), .rxBlkSwTrig(rxBlkSwTrig),
    .ofsNeedSync(ofsNeedSync), .ofsCfgA(ofsCfgA), .ofsCfgB(ofsCfgB),
    .gainCfg(gainCfg), .phaseCfg(phaseCfg),
    .txStrobe(txStrobe), .rxStrobe(rxStrobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .ofsActA(ofsActA), .ofsActB(ofsActB), .gainAct(gainAct), .phaseAct(phaseAct)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic testReset();
    chk("R1 tx strobes", 32'(txStrobe), 0);
    chk("R1 rx strobes", 32'(rxStrobe), 0);
    chk("R1 wrPtr", 32'(wrPtr), 0);
    chk("R1 rdPtr", 32'(rdPtr), 4);
    chk("R1 offsets", {ofsActA, ofsActB}, 0);
    chk("R1 gain/phase", {gainAct, phaseAct}, 0);
  endtask

  task automatic testPinGlobal();
    syncPin = 1;
    step(); chk("R2 no strobe after edge k", 32'(txStrobe), 0);
    step(); chk("R2 no strobe after edge k+1", 32'(txStrobe), 0);
    step(); chk("R2 tx divider after k+2", 32'(txStrobe), 6'b000001);
    chk("R2 rx divider after k+2", 32'(rxStrobe), 6'b000001);
    step(); chk("R4 fifo second", 32'(txStrobe), 6'b000010);
    step(); chk("R4 rest third", 32'(txStrobe), 6'b111100);
    chk("R7 wrPtr after fifo strobe", 32'(wrPtr), 0);
    chk("R7 rdPtr after fifo strobe", 32'(rdPtr), 4);
    step(); chk("R4 sequence ends", 32'(txStrobe), 0);
    chk("R7 wrPtr advances", 32'(wrPtr), 1);
    chk("R7 rdPtr advances", 32'(rdPtr), 5);
    step(4);
    chk("R7 rdPtr wraps", 32'(rdPtr), 1);
    syncPin = 0;
    for (int i = 0; i < 5; i++) begin
      step(); chk("R2 falling edge silent", 32'(txStrobe | rxStrobe), 0);
    end
  endtask

  task automatic testSwGlobal();
    txSrcSw = 1;
    syncPin = 1;
    step(2); chk("R3 tx ignores pin", 32'(txStrobe), 0);
    step(); chk("R10 tx stays silent", 32'(txStrobe), 0);
    chk("R10 rx fires on pin", 32'(rxStrobe), 6'b000001);
    step(3); syncPin = 0; step(4);
    txSwTrig = 1;
    step(); chk("R3 sw divider same edge", 32'(txStrobe), 6'b000001);
    chk("R10 rx silent on tx sw", 32'(rxStrobe), 0);
    step(); chk("R3 sw fifo", 32'(txStrobe), 6'b000010);
    step(); chk("R3 sw rest", 32'(txStrobe), 6'b111100);
    step(2); chk("R3 held high no repeat", 32'(txStrobe), 0);
    txSwTrig = 0; step();
  endtask

  task automatic testBusy();
    txSwTrig = 1; step(); chk("R5 first div", 32'(txStrobe), 6'b000001);
    txSwTrig = 0; step(); chk("R5 fifo", 32'(txStrobe), 6'b000010);
    txSwTrig = 1; step(); chk("R5 rest", 32'(txStrobe), 6'b111100);
    step(); chk("R5 mid-sequence trigger dropped", 32'(txStrobe), 0);
    step(); chk("R5 still idle", 32'(txStrobe), 0);
    txSwTrig = 0; step();
  endtask

  task automatic testPerBlock();
    txGlobalDis = 1; txSrcSw = 1; txBlkEn = 6'b000101;
    txSwTrig = 1; step(); chk("R6 global bit ignored", 32'(txStrobe), 0);
    txSwTrig = 0;
    txBlkSwTrig = 6'b111111; step();
    chk("R6 sw enabled blocks only", 32'(txStrobe), 6'b000101);
    step(); chk("R6 single pulse", 32'(txStrobe), 0);
    txBlkSwTrig = 0; step();
    txSrcSw = 0; txBlkEn = 6'b100010;
    syncPin = 1;
    step(2); chk("R6 pin latency", 32'(txStrobe), 0);
    step(); chk("R6 pin enabled blocks", 32'(txStrobe), 6'b100010);
    step(); chk("R6 pin single pulse", 32'(txStrobe), 0);
    syncPin = 0; step(3);
    txGlobalDis = 0; txSrcSw = 1; txBlkEn = 0;
  endtask

  task automatic testOffsetQmc();
    ofsNeedSync = 0; ofsCfgA = 13'h1000; ofsCfgB = 13'h0FFF;
    step(); chk("R8 immediate offsets", {ofsActA, ofsActB}, {13'h1000, 13'h0FFF});
    ofsNeedSync = 1; ofsCfgA = 13'h0123; ofsCfgB = 13'h1F00;
    gainCfg = 12'hABC; phaseCfg = 12'h123;
    step(2); chk("R8 offsets held", {ofsActA, ofsActB}, {13'h1000, 13'h0FFF});
    txSwTrig = 1; step(3);
    chk("R8 held until strobe done", {ofsActA, ofsActB}, {13'h1000, 13'h0FFF});
    chk("R9 held before load", {gainAct, phaseAct}, 0);
    step(); chk("R8 offsets loaded", {ofsActA, ofsActB}, {13'h0123, 13'h1F00});
    chk("R9 gain/phase loaded", {gainAct, phaseAct}, {12'hABC, 12'h123});
    txSwTrig = 0; gainCfg = 12'h555; step(2);
    chk("R9 gain holds", 32'(gainAct), 12'hABC);
  endtask

  initial begin
    step(2);
    testReset();
    rstN = 1;
    step();
    testPinGlobal();
    testSwGlobal();
    testBusy();
    testPerBlock();
    testOffsetQmc();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule